// File: doc/BRIEF.md
# Limit-Compare Periodic Counter-Timer

This block is a 32-bit counter-timer that software reaches through a small word-addressed register window. It accepts only full 32-bit accesses. Each time the tick-enable input is high on a clock edge, the count advances by one unit. A count unit sits at bit 9 of the register word, so bits 8..0 always read as zero. Bits 30..9 hold the count and bit 31 reports a sticky "limit reached" flag.

Software programs a limit. When a tick carries the count onto a nonzero limit, three things happen at once:
- the count restarts from zero;
- the reached flag is set;
- a level interrupt is raised.

The interrupt stays high until software acknowledges it. Reading the limit clears both the flag and the interrupt. Rewriting the limit through the resetting address also drops the interrupt, but the flag stays set.

A limit of zero selects free-run: the count wraps by itself and never flags or interrupts. A second write address changes the limit without disturbing the running count, so the period can be changed on the fly.

Top module: `ltmr_timer`

## Requirements
- R1: After reset the limit is zero, the count is zero, the reached flag and `irq` are low, and the counter runs on the first tick with no setup.
- R2: Each cycle with `tick_en` high adds 0x200 to the count value (one unit in bit 9). Cycles without a tick leave the count unchanged. Bits 8..0 of the count always read zero.
- R3: A read of byte address 0x4 returns the reached flag in bit 31 and the count in bits 30..9. Read data appears on `rdata` in the cycle after the cycle where `rd_en` is high.
- R4: A write to byte address 0x0 stores `wdata & 0x7FFFFE00` as the limit, sets the count to zero and drops `irq`. It leaves the reached flag as it was.
- R5: A write to byte address 0x8 stores the limit with the same mask and leaves the count unchanged.
- R6: With a nonzero limit, the tick that would make the count equal the limit makes it zero instead, sets the reached flag and raises `irq` on the next cycle.
- R7: With a limit of zero, the count keeps counting and wraps from 0x7FFFFE00 to zero. The reached flag and `irq` stay low.
- R8: A read of byte address 0x0 returns the limit with bit 31 clear, and clears the reached flag and `irq`. If a limit hit happens in the same cycle, the hit wins.
- R9: Reads of byte addresses other than 0x0 and 0x4 return zero. Writes to 0x4 and to unmapped addresses change no state.
- R10: Once raised, `irq` stays high through further ticks and limit hits until a read of 0x0 or a write of 0x0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the count by one unit this cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address; word index is addr >> 2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after rd_en |
| irq | output | 1 | Level interrupt, held until acknowledged |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that no register access falls in a cycle where `tick_en` is high. The stimulus keeps to both rules: accesses and ticks are driven in separate cycles. The properties themselves stay valid when a tick and a limit acknowledge coincide, because a hit takes precedence. The free-run wrap needs about four million ticks, far too many for the stimulus to reach. It is therefore covered by a property on the all-ones count. The bench checks only the absence of any flag or interrupt in free-run.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int DATA_W = 32;
  localparam int FRAC_W = 9;
  localparam int CNT_W  = DATA_W - 1 - FRAC_W;

  localparam logic [DATA_W-1:0] LIM_MASK = {1'b0, {CNT_W{1'b1}}, {FRAC_W{1'b0}}};

  localparam int OFF_LIM_RST  = 0;
  localparam int OFF_COUNT    = 1;
  localparam int OFF_LIM_KEEP = 2;

  // place a count value into its register position, flag bit supplied
  function automatic logic [DATA_W-1:0] pack_count(input logic flag,
                                                   input logic [CNT_W-1:0] c);
    return {flag, c, {FRAC_W{1'b0}}};
  endfunction

  // masked limit word from raw write data
  function automatic logic [DATA_W-1:0] limit_of(input logic [DATA_W-1:0] w);
    return w & LIM_MASK;
  endfunction
endpackage

// File: rtl/ltmr_decode.sv
module ltmr_decode #(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_lim_rst,
  output logic              wr_lim_keep,
  output logic              rd_lim,
  output logic              rd_cnt
);
  import ltmr_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;

  always_comb begin
    word_idx    = IDX_W'(addr >> 2);
    wr_lim_rst  = wr_en && (word_idx == IDX_W'(OFF_LIM_RST));
    wr_lim_keep = wr_en && (word_idx == IDX_W'(OFF_LIM_KEEP));
    rd_lim      = rd_en && (word_idx == IDX_W'(OFF_LIM_RST));
    rd_cnt      = rd_en && (word_idx == IDX_W'(OFF_COUNT));
  end
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_en,
  input  logic                         wr_lim_rst,
  input  logic                         wr_lim_keep,
  input  logic                         rd_lim,
  input  logic [ltmr_pkg::DATA_W-1:0]  wdata,
  output logic [ltmr_pkg::CNT_W-1:0]   cnt_q,
  output logic [ltmr_pkg::DATA_W-1:0]  lim_q,
  output logic                         reached_q,
  output logic                         irq_q,
  output logic                         hit_evt
);
  import ltmr_pkg::*;

  logic [CNT_W-1:0] cnt_inc;
  logic             lim_nz;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    lim_nz  = (lim_q != '0);
    hit_evt = tick_en && lim_nz && !wr_lim_rst && (pack_count(1'b0, cnt_inc) == lim_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_lim_rst || wr_lim_keep) lim_q <= limit_of(wdata);

      if (wr_lim_rst)   cnt_q <= '0;
      else if (hit_evt) cnt_q <= '0;
      else if (tick_en) cnt_q <= cnt_inc;

      if (hit_evt)     reached_q <= 1'b1;
      else if (rd_lim) reached_q <= 1'b0;

      if (hit_evt)                    irq_q <= 1'b1;
      else if (rd_lim || wr_lim_rst)  irq_q <= 1'b0;
    end
  end

  AST_HIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (cnt_q == '0) && reached_q && irq_q); // R6

  AST_FREE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0 && !irq_q && !reached_q) |=> (!irq_q && !reached_q)); // R7

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0 && tick_en && !wr_lim_rst && (&cnt_q)) |=> (cnt_q == '0)); // R7

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_lim || wr_lim_rst) && !hit_evt) |=> !irq_q); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !rd_lim && !wr_lim_rst) |=> irq_q); // R10

  AST_KEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim_keep && !tick_en) |=> $stable(cnt_q)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_lim_rst) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/ltmr_readback.sv
module ltmr_readback (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic                         rd_lim,
  input  logic                         rd_cnt,
  input  logic [ltmr_pkg::CNT_W-1:0]   cnt_q,
  input  logic [ltmr_pkg::DATA_W-1:0]  lim_q,
  input  logic                         reached_q,
  output logic [ltmr_pkg::DATA_W-1:0]  rdata
);
  import ltmr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (rd_lim)      rdata <= lim_q;
      else if (rd_cnt) rdata <= pack_count(reached_q, cnt_q);
      else             rdata <= '0;
    end
  end

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[FRAC_W-1:0] == '0); // R2

  AST_LIM_BIT31_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lim |=> !rdata[DATA_W-1]); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_lim && !rd_cnt) |=> (rdata == '0)); // R9
endmodule

// File: rtl/ltmr_timer.sv
module ltmr_timer #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  import ltmr_pkg::*;

  logic              wr_lim_rst, wr_lim_keep, rd_lim, rd_cnt;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] lim_q;
  logic              reached_q, irq_q, hit_evt;

  ltmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wr_lim_rst  (wr_lim_rst),
    .wr_lim_keep (wr_lim_keep),
    .rd_lim      (rd_lim),
    .rd_cnt      (rd_cnt)
  );

  ltmr_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .wr_lim_rst  (wr_lim_rst),
    .wr_lim_keep (wr_lim_keep),
    .rd_lim      (rd_lim),
    .wdata       (wdata),
    .cnt_q       (cnt_q),
    .lim_q       (lim_q),
    .reached_q   (reached_q),
    .irq_q       (irq_q),
    .hit_evt     (hit_evt)
  );

  ltmr_readback u_readback (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_lim      (rd_lim),
    .rd_cnt      (rd_cnt),
    .cnt_q       (cnt_q),
    .lim_q       (lim_q),
    .reached_q   (reached_q),
    .rdata       (rdata)
  );

  assign irq = irq_q;

  AST_IRQ_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit_evt)); // R6

  AST_REACHED_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reached_q) |-> $past(lim_q != '0)); // R7
endmodule

// File: tb/ltmr_timer_tb_top.sv
module ltmr_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ltmr_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // expected count word: bit 31 flag, count units at bit 9
  function automatic logic [31:0] cword(input bit flag, input int units);
    return {flag, 31'(units * 512)};
  endfunction

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pop expected read data one cycle after each read strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rd_seen && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s rdata=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic do_read(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    do_read(5'h04, 32'h0, "R1 count after reset");
    do_read(5'h00, 32'h0, "R1 limit after reset");
    // R2 / R3 counting from reset
    do_ticks(5);
    do_read(5'h04, cword(0, 5), "R2 count after 5 ticks");
    repeat (4) @(negedge clk);
    do_read(5'h04, cword(0, 5), "R2 count holds without tick");
    // R9 ignored writes, unmapped reads
    do_write(5'h04, 32'h12345600);
    do_write(5'h0C, 32'hFFFFFFFF);
    do_write(5'h10, 32'hFFFFFFFF);
    do_read(5'h04, cword(0, 5), "R9 count after ignored writes");
    do_read(5'h00, 32'h0, "R9 limit after ignored writes");
    do_read(5'h0C, 32'h0, "R9 unmapped read 0xC");
    do_read(5'h10, 32'h0, "R9 unmapped read 0x10");
    // R4 mask and count reset
    do_write(5'h00, 32'hFFFFFFFF);
    do_read(5'h00, 32'h7FFFFE00, "R4 masked limit");
    do_read(5'h04, 32'h0, "R4 count reset by write");
    // R6 hit with limit 4 units; low bits of wdata dropped
    do_write(5'h00, 32'h000009FF);
    do_ticks(3);
    do_read(5'h04, cword(0, 3), "R6 count before limit");
    chk_irq(1'b0, "R6 irq before limit");
    do_ticks(1);
    chk_irq(1'b1, "R6 irq on limit");
    do_read(5'h04, cword(1, 0), "R6 count restart and flag");
    // R10 irq held through more ticks
    do_ticks(2);
    chk_irq(1'b1, "R10 irq held");
    do_read(5'h04, cword(1, 2), "R3 flag with count");
    // R8 limit read acknowledges
    do_read(5'h00, 32'h00000800, "R8 limit read value");
    chk_irq(1'b0, "R8 irq cleared by limit read");
    do_read(5'h04, cword(0, 2), "R8 flag cleared by limit read");
    // R4 write drops irq, keeps flag
    do_ticks(2);
    chk_irq(1'b1, "R6 second hit irq");
    do_write(5'h00, 32'h00001000);
    chk_irq(1'b0, "R4 irq cleared by limit write");
    do_read(5'h04, cword(1, 0), "R4 flag kept by limit write");
    do_read(5'h00, 32'h00001000, "R8 limit read 8 units");
    // R5 limit change without count reset
    do_ticks(3);
    do_write(5'h08, 32'h80000C00);
    do_read(5'h04, cword(0, 3), "R5 count kept");
    do_read(5'h00, 32'h00000C00, "R5 new limit masked");
    do_ticks(2);
    chk_irq(1'b0, "R5 no hit before new limit");
    do_ticks(1);
    chk_irq(1'b1, "R5 hit at new limit");
    do_read(5'h04, cword(1, 0), "R5 restart at new limit");
    do_read(5'h00, 32'h00000C00, "R8 acknowledge");
    // R7 free-run
    do_write(5'h00, 32'h0);
    chk_irq(1'b0, "R7 irq low in free-run");
    do_ticks(300);
    chk_irq(1'b0, "R7 no irq after 300 ticks");
    do_read(5'h04, cword(0, 300), "R7 free-run count no flag");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule